// File: doc/BRIEF.md
# Stereo Serial Audio Receiver with Word-Length Adaptation

The block receives a three-wire stereo audio stream made of a bit clock, a channel-select line and a serial data line. It turns that stream into parallel left and right samples of one fixed width, `OUT_W`, whatever word length the sender uses. The three lines come from outside and are not related to the system clock. Each one passes through a two-stage synchronizer, and a rising bit-clock edge is detected in the system clock domain. The system clock must run at least four times faster than the bit clock.

Word boundaries come only from transitions of the channel-select line. Every bit is placed from the MSB downward. When a word is shorter than `OUT_W`, its missing low bits are zero. When a word is longer, the bits past `OUT_W` are dropped. A static mode input chooses between two framings. In the standard framing the MSB follows the select edge by one bit period. In the left-aligned framing the MSB arrives with the select edge. The receiver holds each left sample until its right partner is complete. It then presents both samples together with a one-cycle strobe.

Top module: `aud_serial_rx`

## Requirements
- R1: While `rst_n` is low, and on the cycle after it rises, `valid_o` is 0 and `left_o` and `right_o` are all zeros.
- R2: A rising bit-clock level first sampled at system edge n produces its result at the outputs from edge n+2 onward (two synchronizer flops plus one processing register).
- R3: A word sent while the select line is 0 is a left sample. A word sent while it is 1 is a right sample.
- R4: Bits arrive MSB first. With `lj_mode`=0 (standard framing), the MSB of a word is the bit one bit period after the select transition.
- R5: With `lj_mode`=1 (left-aligned framing), the MSB of a word is the bit sampled on the same bit-clock rise that first shows the new select level.
- R6: A word shorter than `OUT_W` bits fills the upper bits of the sample. The remaining low bits are zero.
- R7: A word longer than `OUT_W` bits keeps only its first `OUT_W` bits. The later bits are discarded.
- R8: `valid_o` is high for exactly one system clock, on the bit-clock rise that ends a right word which followed a complete left word. `left_o` and `right_o` change only together with that strobe.
- R9: After reset, any word that began before the first detected boundary is discarded. A right word that has no complete left word before it produces no strobe.
- R10: A boundary is taken only from a change of the effective select level, and only from the third bit-clock rise after reset onward. If the select line never changes, no strobe is produced, however many bits arrive.
- R11: Consecutive rising bit-clock edges, as seen in the system domain, are at least four system clocks apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lj_mode | input | 1 | Framing select: 0 = standard (one-bit delay), 1 = left-aligned. Held static |
| bclk_i | input | 1 | External serial bit clock |
| ws_i | input | 1 | External channel-select line (0 = left, 1 = right) |
| sd_i | input | 1 | External serial data, MSB first |
| left_o | output | OUT_W | Last completed left sample |
| right_o | output | OUT_W | Last completed right sample |
| valid_o | output | 1 | One-cycle strobe marking a new stereo pair |

## Verification
The bench drives its pins just after each falling system-clock edge. A strobe or sample update caused by a bit-clock rise is therefore due exactly three falling edges after the rise was driven. The behavioural reference model puts each cycle's expected output into a three-deep queue and compares it with the design on every falling edge. This checks the position of the strobe in time, not just its value. Separately, every received pair is matched against the samples the bench sent, after padding or truncation to `OUT_W`. The number of strobes per scenario must equal the number of full frames, which catches dropped or spurious partial words.

// File: rtl/aud_rx_pkg.sv
// Shared types for the serial audio receiver.
package aud_rx_pkg;
    // Channel encoding carried by the select line.
    typedef enum logic {
        CH_LEFT  = 1'b0,
        CH_RIGHT = 1'b1
    } chan_e;
endpackage

// File: rtl/aud_rx_sync.sv
// Bank of multi-stage synchronizers, one chain per input bit.
// Assumes each input is a level that stays stable for several clk cycles.
module aud_rx_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain;

    // First stage samples the asynchronous inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= '0;
        else        chain[0] <= d;
    end

    genvar s;
    generate
        for (s = 1; s < STAGES; s++) begin : g_stage
            // Each later stage re-times the previous one.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[s] <= '0;
                else        chain[s] <= chain[s-1];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/aud_rx_edge.sv
// Bit-clock rise detector and word-boundary finder.
// Assumes synchronized inputs. The effective select level is the raw level
// (left-aligned) or the level from the previous bit (standard framing).
// Boundaries are reported only once two rises have primed the history.
module aud_rx_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lj_mode,
    input  logic bclk_s,
    input  logic ws_s,
    output logic bclk_rise,
    output logic word_end,
    output logic end_chan
);
    logic       bclk_d;
    logic       ws_last;
    logic       eff_prev;
    logic [1:0] prime_cnt;
    logic       eff_now;

    assign bclk_rise = bclk_s & ~bclk_d;
    assign eff_now   = lj_mode ? ws_s : ws_last;
    assign word_end  = bclk_rise && (prime_cnt == 2'd2) && (eff_now != eff_prev);
    assign end_chan  = eff_prev;

    // Track bit-clock history, select history and the priming count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bclk_d    <= 1'b0;
            ws_last   <= 1'b0;
            eff_prev  <= 1'b0;
            prime_cnt <= 2'd0;
        end else begin
            bclk_d <= bclk_s;
            if (bclk_rise) begin
                ws_last  <= ws_s;
                eff_prev <= eff_now;
                if (prime_cnt != 2'd2) prime_cnt <= prime_cnt + 2'd1;
            end
        end
    end
endmodule

// File: rtl/aud_rx_word.sv
// Serial-to-parallel word assembler with width adaptation.
// Bits fill the word MSB first. Bits past OUT_W are dropped, unfilled
// bits stay zero. The word is complete when word_end is seen.
module aud_rx_word #(
    parameter int OUT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bclk_rise,
    input  logic             word_end,
    input  logic             sd_s,
    output logic [OUT_W-1:0] word,
    output logic             word_ok
);
    localparam int CW = $clog2(OUT_W + 1);
    localparam int IW = (OUT_W > 1) ? $clog2(OUT_W) : 1;

    logic [OUT_W-1:0] acc;
    logic [CW-1:0]    cnt;
    logic             started;
    logic [IW-1:0]    wr_pos;

    assign wr_pos  = IW'(OUT_W - 1) - IW'(cnt);
    assign word    = acc;
    assign word_ok = started;

    // Start a new word on a boundary, otherwise place the next bit if room remains.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc     <= '0;
            cnt     <= '0;
            started <= 1'b0;
        end else if (bclk_rise) begin
            if (word_end) begin
                acc     <= {sd_s, {(OUT_W-1){1'b0}}};
                cnt     <= CW'(1);
                started <= 1'b1;
            end else if (cnt < CW'(OUT_W)) begin
                acc[wr_pos] <= sd_s;
                cnt         <= cnt + CW'(1);
            end
        end
    end
endmodule

// File: rtl/aud_rx_frame.sv
// Pairs completed words into stereo frames and drives the outputs.
// A left word is held until its right partner completes. Words from
// before the first boundary (word_ok low) are ignored.
module aud_rx_frame #(
    parameter int OUT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             word_end,
    input  logic             end_chan,
    input  logic [OUT_W-1:0] word,
    input  logic             word_ok,
    output logic [OUT_W-1:0] left_o,
    output logic [OUT_W-1:0] right_o,
    output logic             valid_o
);
    import aud_rx_pkg::*;

    logic [OUT_W-1:0] left_hold;
    logic             left_ok;
    chan_e            ch;

    assign ch = chan_e'(end_chan);

    // Latch left words and publish a pair when a right word closes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_hold <= '0;
            left_ok   <= 1'b0;
            left_o    <= '0;
            right_o   <= '0;
            valid_o   <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (word_end && word_ok) begin
                if (ch == CH_LEFT) begin
                    left_hold <= word;
                    left_ok   <= 1'b1;
                end else if (left_ok) begin
                    left_o  <= left_hold;
                    right_o <= word;
                    valid_o <= 1'b1;
                    left_ok <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/aud_serial_rx.sv
// Top of the stereo serial audio receiver.
// Assumes clk is at least 4x the bit clock and lj_mode is static.
module aud_serial_rx #(
    parameter int OUT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lj_mode,
    input  logic             bclk_i,
    input  logic             ws_i,
    input  logic             sd_i,
    output logic [OUT_W-1:0] left_o,
    output logic [OUT_W-1:0] right_o,
    output logic             valid_o
);
    logic             bclk_s, ws_s, sd_s;
    logic             bclk_rise, word_end, end_chan;
    logic [OUT_W-1:0] word;
    logic             word_ok;

    aud_rx_sync #(.W(3), .STAGES(2)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({bclk_i, ws_i, sd_i}),
        .q     ({bclk_s, ws_s, sd_s})
    );

    aud_rx_edge edge_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .lj_mode   (lj_mode),
        .bclk_s    (bclk_s),
        .ws_s      (ws_s),
        .bclk_rise (bclk_rise),
        .word_end  (word_end),
        .end_chan  (end_chan)
    );

    aud_rx_word #(.OUT_W(OUT_W)) word_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bclk_rise (bclk_rise),
        .word_end  (word_end),
        .sd_s      (sd_s),
        .word      (word),
        .word_ok   (word_ok)
    );

    aud_rx_frame #(.OUT_W(OUT_W)) frame_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .word_end (word_end),
        .end_chan (end_chan),
        .word     (word),
        .word_ok  (word_ok),
        .left_o   (left_o),
        .right_o  (right_o),
        .valid_o  (valid_o)
    );
endmodule

// File: rtl/aud_serial_rx_chk.sv
// Property checker for the serial audio receiver, attached by bind.
module aud_serial_rx_chk #(
    parameter int OUT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bclk_rise,
    input logic             valid_o,
    input logic [OUT_W-1:0] left_o,
    input logic [OUT_W-1:0] right_o
);
    logic [3:0] gap;
    logic       seen_rise;

    // Count system clocks since the last detected bit-clock rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap       <= 4'd0;
            seen_rise <= 1'b0;
        end else if (bclk_rise) begin
            gap       <= 4'd0;
            seen_rise <= 1'b1;
        end else if (gap != 4'hF) begin
            gap <= gap + 4'd1;
        end
    end

    p_rst_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!valid_o && left_o == '0 && right_o == '0));

    p_valid_after_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $past(bclk_rise));

    p_single_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    p_hold_outputs_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_o && $past(rst_n)) |-> ($stable(left_o) && $stable(right_o)));

    p_rise_spacing_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bclk_rise && seen_rise) |-> (gap >= 4'd3));
endmodule

bind aud_serial_rx aud_serial_rx_chk #(.OUT_W(OUT_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bclk_rise (bclk_rise),
    .valid_o   (valid_o),
    .left_o    (left_o),
    .right_o   (right_o)
);

// File: tb/aud_serial_rx_tb_top.sv
// Bench: behavioural reference model compared every clock, plus per-frame checks.
module aud_serial_rx_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int OUT_W      = 16;

    typedef struct packed {
        logic             v;
        logic [OUT_W-1:0] l;
        logic [OUT_W-1:0] r;
    } obs_t;

    logic clk = 1'b0, rst_n = 1'b0, lj_mode = 1'b0;
    logic bclk = 1'b0, ws = 1'b0, sd = 1'b0;
    logic [OUT_W-1:0] left_o, right_o;
    logic             valid_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    aud_serial_rx #(.OUT_W(OUT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .lj_mode(lj_mode),
        .bclk_i(bclk), .ws_i(ws), .sd_i(sd),
        .left_o(left_o), .right_o(right_o), .valid_o(valid_o)
    );

    int checks = 0, fails = 0;
    bit done = 1'b0;

    // Reference model state
    obs_t pipe[$];
    obs_t last_exp;
    int   m_idx;
    bit   m_started, m_have_l, m_eff_hist, m_ws_prev;
    bit   m_cur[$];
    logic [OUT_W-1:0] m_lhold;

    // Stimulus and results
    bit ws_q[$], sd_q[$];
    logic [OUT_W-1:0] exp_l[$], exp_r[$], got_l[$], got_r[$];

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [OUT_W-1:0] pack_bits();
        logic [OUT_W-1:0] v = '0;
        for (int k = 0; k < OUT_W; k++)
            if (k < m_cur.size()) v[OUT_W-1-k] = m_cur[k];
        return v;
    endfunction

    // Process one bit-clock rise in the model.
    function automatic void model_bit(input bit w, input bit d, inout obs_t e);
        bit eff = lj_mode ? w : m_ws_prev;
        if (m_idx >= 2 && eff != m_eff_hist) begin
            if (m_started) begin
                if (!m_eff_hist) begin
                    m_lhold  = pack_bits();
                    m_have_l = 1'b1;
                end else if (m_have_l) begin
                    e.v = 1'b1; e.l = m_lhold; e.r = pack_bits();
                    m_have_l = 1'b0;
                end
            end
            m_started = 1'b1;
            m_cur.delete();
        end
        m_cur.push_back(d);
        m_eff_hist = eff;
        m_ws_prev  = w;
        m_idx++;
    endfunction

    // One system cycle: compare, capture, drive, model.
    task automatic tick(input bit nb, input bit nw, input bit nd);
        obs_t e, n;
        bit   rise;
        @(negedge clk);
        e = pipe.pop_front();
        check({valid_o, left_o, right_o} == e, "R2 cycle compare",
              {valid_o, left_o, right_o}, e);
        if (valid_o) begin
            got_l.push_back(left_o);
            got_r.push_back(right_o);
        end
        rise = nb && !bclk;
        bclk = nb; ws = nw; sd = nd;
        n = '{v: 1'b0, l: last_exp.l, r: last_exp.r};
        if (rise) model_bit(nw, nd, n);
        pipe.push_back(n);
        last_exp = n;
    endtask

    task automatic do_reset(input bit mode);
        rst_n = 1'b0; bclk = 1'b0; ws = 1'b0; sd = 1'b0; lj_mode = mode;
        repeat (3) @(negedge clk);
        check(valid_o == 1'b0 && left_o == '0 && right_o == '0, "R1 reset outputs",
              {valid_o, left_o, right_o}, 0);
        m_idx = 0; m_started = 0; m_have_l = 0; m_eff_hist = 0; m_ws_prev = 0;
        m_cur.delete(); m_lhold = '0; last_exp = '0;
        pipe.delete();
        repeat (3) pipe.push_back('0);
        ws_q.delete(); sd_q.delete();
        exp_l.delete(); exp_r.delete(); got_l.delete(); got_r.delete();
        rst_n = 1'b1;
    endtask

    task automatic add_word(input bit w, input int len, input logic [31:0] val);
        for (int b = len - 1; b >= 0; b--) begin
            ws_q.push_back(w);
            sd_q.push_back(val[b]);
        end
    endtask

    function automatic logic [OUT_W-1:0] adapt(input logic [31:0] v, input int len);
        logic [31:0] t = (len >= OUT_W) ? (v >> (len - OUT_W)) : (v << (OUT_W - len));
        return t[OUT_W-1:0];
    endfunction

    task automatic add_frames(input int n, input int len);
        for (int f = 0; f < n; f++) begin
            logic [31:0] lv = $urandom() & ((32'h1 << len) - 1);
            logic [31:0] rv = $urandom() & ((32'h1 << len) - 1);
            add_word(1'b0, len, lv);
            add_word(1'b1, len, rv);
            exp_l.push_back(adapt(lv, len));
            exp_r.push_back(adapt(rv, len));
        end
        add_word(1'b0, 4, 32'h5);
    endtask

    // Play the queued stream; standard framing moves the select one bit earlier.
    task automatic play(input int half);
        int n = ws_q.size();
        for (int i = 0; i < n; i++) begin
            bit w = lj_mode ? ws_q[i] : ((i + 1 < n) ? ws_q[i+1] : ws_q[i]);
            repeat (half) tick(1'b0, w, sd_q[i]);
            repeat (half) tick(1'b1, w, sd_q[i]);
        end
        repeat (8) tick(1'b0, ws, 1'b0);
    endtask

    task automatic finish_scn(input string tag);
        check(got_l.size() == exp_l.size(), {tag, " R8 pair count"}, got_l.size(), exp_l.size());
        for (int k = 0; k < exp_l.size() && k < got_l.size(); k++) begin
            check(got_l[k] == exp_l[k], {tag, " left"},  got_l[k], exp_l[k]);
            check(got_r[k] == exp_r[k], {tag, " right"}, got_r[k], exp_r[k]);
        end
    endtask

    initial begin
        // R3 R4: standard framing, matched 16-bit words
        do_reset(1'b0);
        add_word(1'b1, 3, 32'h5); add_frames(3, 16); play(4);
        finish_scn("R3 R4");
        // R5: left-aligned framing
        do_reset(1'b1);
        add_word(1'b1, 3, 32'h2); add_frames(3, 16); play(4);
        finish_scn("R5");
        // R6: short words padded
        do_reset(1'b0);
        add_word(1'b1, 3, 32'h7); add_frames(3, 12); play(4);
        finish_scn("R6");
        // R7: long words truncated, left-aligned
        do_reset(1'b1);
        add_word(1'b1, 5, 32'h1B); add_frames(2, 24); play(4);
        finish_scn("R7");
        // R9: stream opens mid right word
        do_reset(1'b0);
        add_word(1'b1, 9, 32'h1A5); add_frames(2, 16); play(4);
        finish_scn("R9 partial right");
        // R9: stream opens mid left word, then an orphan right word
        do_reset(1'b0);
        add_word(1'b0, 5, 32'h13); add_word(1'b1, 16, 32'hBEEF); add_frames(2, 16); play(4);
        finish_scn("R9 orphan right");
        // R11: fastest allowed bit clock (4 system clocks per bit)
        do_reset(1'b0);
        add_word(1'b1, 3, 32'h3); add_frames(3, 16); play(2);
        finish_scn("R11");
        // R10: select never changes, no strobe
        do_reset(1'b1);
        add_word(1'b0, 32, 32'hDEADBEEF); add_word(1'b0, 32, 32'h12345678); play(4);
        check(got_l.size() == 0, "R10 no strobe without select change", got_l.size(), 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL R2 watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule